// File: doc/BRIEF.md
# Dual-Source Cycle Clock Generator

This block produces the instruction-cycle enable of a small microcontroller and the enable strobes that its peripherals and its time-keeping timer count on. Two oscillator sources reach it as single-cycle tick strobes in the system clock domain. `main_tick` marks each period of the main oscillator and `sub_tick` marks each period of the 32.768 kHz subclock. Both are already synchronised upstream, so every divided clock leaves the block as a one-cycle enable pulse and never as a derived clock.

In active mode the cycle enable is the main oscillator divided by 4, 8, 16 or 32. In sub-active mode it is the subclock divided by 4 or 8. The CPU and the peripherals use this same cycle enable. It steps an 11-bit peripheral prescaler whose taps each peripheral can choose from. A separate watch prescaler is fed by the subclock divided by 8 and keeps running whatever the mode is.

Selection inputs are sampled only at a cycle boundary. A change therefore never produces a shortened cycle.

Top module: `dcg_top`

## Requirements
- R1: After reset the block uses divide by 32 in active mode, all outputs are low, and the first `cyc_en` appears only after the 32nd `main_tick`.
- R2: In active mode `cyc_en` pulses once every 4, 8, 16 or 32 `main_tick` strobes for `div_sel` = 00, 01, 10 or 11 respectively.
- R3: A new `div_sel` value takes effect only after the `cyc_en` that ends the current cycle. The cycle in progress always completes at its old length.
- R4: With sub-active mode in effect (`sub_mode` = 1), `cyc_en` pulses once every 4 `sub_tick` strobes when `sub_div_sel` = 0 and every 8 when it is 1, and `main_tick` has no effect on it. `sub_div_sel` is also latched only at a cycle boundary.
- R5: `sub_mode` is latched at a cycle boundary. While active mode is in effect, `sub_tick` does not produce `cyc_en`. While sub-active mode is in effect, the main divider is held at zero, so that after a return to active mode the first `cyc_en` needs a full divisor count of `main_tick` strobes.
- R6: Bit i of `psc_tap` pulses in the same cycle as every 2^(i+1)-th `cyc_en`, counted from reset, and never without `cyc_en`.
- R7: Bit j of `watch_tap` pulses once every 16·2^j `sub_tick` strobes counted from reset, whatever the mode is and whatever mode changes occur.
- R8: Every output is a pulse one clock long, asserted in the clock cycle after the edge that sampled the qualifying tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| main_tick | input | 1 | One-cycle strobe per main oscillator period |
| sub_tick | input | 1 | One-cycle strobe per subclock period |
| div_sel | input | 2 | Main divisor select: 00 /4, 01 /8, 10 /16, 11 /32 |
| sub_div_sel | input | 1 | Subclock divisor select: 0 /4, 1 /8 |
| sub_mode | input | 1 | 1 requests sub-active mode, 0 requests active mode |
| cyc_en | output | 1 | Instruction-cycle enable, shared by the CPU and the peripherals |
| psc_tap | output | PSC_BITS | Peripheral prescaler tap enables |
| watch_tap | output | WP_BITS | Watch prescaler tap enables |

## Verification
The bench changes `div_sel` in the middle of a cycle in both directions, from /32 to /4 and from /4 to /32. A design that applied the change at once would give a short or stretched cycle there, and the bench would see the pulse position move. While in sub-active mode it feeds main ticks, then returns to active mode and counts the first cycle. A divider that was not held would fire early. Dropped or misaligned prescaler taps are caught by counting every tap across 2048 cycle enables. Switching mode partway through the watch run shows whether the watch prescaler stalls or restarts on a mode change.

// File: rtl/dcg_pkg.sv
package dcg_pkg;

  localparam int MAIN_CNT_W = 5;
  localparam int SUB_CNT_W  = 3;

  typedef enum logic [1:0] {
    MDIV_4  = 2'b00,
    MDIV_8  = 2'b01,
    MDIV_16 = 2'b10,
    MDIV_32 = 2'b11
  } main_div_e;

  // terminal count of the main divider for a given select
  function automatic logic [MAIN_CNT_W-1:0] main_last(input main_div_e sel);
    logic [MAIN_CNT_W:0] span;
    span = (MAIN_CNT_W+1)'(4) << sel;
    return MAIN_CNT_W'(span - 1'b1);
  endfunction

  function automatic logic [SUB_CNT_W-1:0] sub_last(input logic by8);
    return by8 ? SUB_CNT_W'(7) : SUB_CNT_W'(3);
  endfunction

endpackage

// File: rtl/dcg_tick_div.sv
module dcg_tick_div #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tick,
  input  logic [W-1:0] last,
  output logic         evt
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         at_last;

  always_comb begin
    at_last = (cnt_q == last);
    evt     = tick & ~clr & at_last;
    cnt_d   = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = at_last ? '0 : cnt_q + {{(W-1){1'b0}}, 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/dcg_prescaler.sv
module dcg_prescaler #(
  parameter int N = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         evt,
  output logic [N-1:0] tap
);

  logic [N-1:0] cnt_q;
  logic [N-1:0] cnt_d;
  logic [N-1:0] tap_d;

  always_comb begin
    cnt_d = evt ? cnt_q + {{(N-1){1'b0}}, 1'b1} : cnt_q;
  end

  // tap i fires when the low i+1 bits are about to wrap
  generate
    for (genvar i = 0; i < N; i++) begin : g_tap
      assign tap_d[i] = evt & (&cnt_q[i:0]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tap   <= '0;
    end else begin
      cnt_q <= cnt_d;
      tap   <= tap_d;
    end
  end

endmodule

// File: rtl/dcg_top.sv
module dcg_top
  import dcg_pkg::*;
#(
  parameter int PSC_BITS = 11,
  parameter int WP_BITS  = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                main_tick,
  input  logic                sub_tick,
  input  logic [1:0]          div_sel,
  input  logic                sub_div_sel,
  input  logic                sub_mode,
  output logic                cyc_en,
  output logic [PSC_BITS-1:0] psc_tap,
  output logic [WP_BITS-1:0]  watch_tap
);

  main_div_e div_q, div_d;
  logic      sdiv_q, sdiv_d;
  logic      mode_q, mode_d;
  logic      cyc_q, cyc_d;
  logic      main_evt, sub_evt, wsub_evt, cyc_evt;

  // main oscillator divider, held at zero during sub-active mode
  dcg_tick_div #(.W(MAIN_CNT_W)) u_main_div (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (mode_q),
    .tick  (main_tick),
    .last  (main_last(div_q)),
    .evt   (main_evt)
  );

  // subclock system divider, held at zero during active mode
  dcg_tick_div #(.W(SUB_CNT_W)) u_sub_div (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (~mode_q),
    .tick  (sub_tick),
    .last  (sub_last(sdiv_q)),
    .evt   (sub_evt)
  );

  // free-running subclock divide by 8 for the watch prescaler
  dcg_tick_div #(.W(SUB_CNT_W)) u_watch_div (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (1'b0),
    .tick  (sub_tick),
    .last  (SUB_CNT_W'(7)),
    .evt   (wsub_evt)
  );

  assign cyc_evt = mode_q ? sub_evt : main_evt;

  // selections are taken over only at a cycle boundary
  always_comb begin
    div_d  = div_q;
    sdiv_d = sdiv_q;
    mode_d = mode_q;
    cyc_d  = cyc_evt;
    if (cyc_evt) begin
      div_d  = main_div_e'(div_sel);
      sdiv_d = sub_div_sel;
      mode_d = sub_mode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= MDIV_32;
      sdiv_q <= 1'b0;
      mode_q <= 1'b0;
      cyc_q  <= 1'b0;
    end else begin
      div_q  <= div_d;
      sdiv_q <= sdiv_d;
      mode_q <= mode_d;
      cyc_q  <= cyc_d;
    end
  end

  assign cyc_en = cyc_q;

  dcg_prescaler #(.N(PSC_BITS)) u_psc (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   (cyc_evt),
    .tap   (psc_tap)
  );

  dcg_prescaler #(.N(WP_BITS)) u_watch_psc (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   (wsub_evt),
    .tap   (watch_tap)
  );

endmodule

// File: rtl/dcg_checker.sv
module dcg_checker #(
  parameter int PSC_BITS = 11,
  parameter int WP_BITS  = 7
) (
  input logic                clk,
  input logic                rst_n,
  input logic                main_tick,
  input logic                sub_tick,
  input logic                cyc_en,
  input logic [PSC_BITS-1:0] psc_tap,
  input logic [WP_BITS-1:0]  watch_tap,
  input logic                mode_q,
  input logic [1:0]          div_q,
  input logic                cyc_evt
);

  p_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_en |=> !cyc_en);

  p_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_en |-> ($past(mode_q) ? $past(sub_tick) : $past(main_tick)));

  p_div_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_evt |=> $stable(div_q));

  p_mode_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_evt |=> $stable(mode_q));

  p_tap_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|psc_tap) |-> cyc_en);

  p_tap_nest_r6: assert property (@(posedge clk) disable iff (!rst_n)
    psc_tap[PSC_BITS-1] |-> psc_tap[0]);

  p_watch_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|watch_tap) |=> !(|watch_tap));

endmodule

bind dcg_top dcg_checker #(.PSC_BITS(PSC_BITS), .WP_BITS(WP_BITS)) u_dcg_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .main_tick (main_tick),
  .sub_tick  (sub_tick),
  .cyc_en    (cyc_en),
  .psc_tap   (psc_tap),
  .watch_tap (watch_tap),
  .mode_q    (mode_q),
  .div_q     (div_q),
  .cyc_evt   (cyc_evt)
);

// File: tb/test_dcg_top.sv
`timescale 1ns/1ps
module test_dcg_top;

  localparam int PSC_BITS = 11;
  localparam int WP_BITS  = 7;

  logic                clk = 1'b0;
  logic                rst_n;
  logic                main_tick, sub_tick, sub_div_sel, sub_mode;
  logic [1:0]          div_sel;
  logic                cyc_en;
  logic [PSC_BITS-1:0] psc_tap;
  logic [WP_BITS-1:0]  watch_tap;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dcg_top #(.PSC_BITS(PSC_BITS), .WP_BITS(WP_BITS)) i_dcg_top (
    .clk(clk), .rst_n(rst_n), .main_tick(main_tick), .sub_tick(sub_tick),
    .div_sel(div_sel), .sub_div_sel(sub_div_sel), .sub_mode(sub_mode),
    .cyc_en(cyc_en), .psc_tap(psc_tap), .watch_tap(watch_tap)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; main_tick = 1'b0; sub_tick = 1'b0;
    div_sel = 2'b11; sub_div_sel = 1'b0; sub_mode = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // one tick strobe, outputs sampled in the cycle after the sampling edge
  task automatic tick(input bit is_sub, output logic c,
                      output logic [PSC_BITS-1:0] p, output logic [WP_BITS-1:0] w);
    @(negedge clk);
    if (is_sub) sub_tick = 1'b1; else main_tick = 1'b1;
    @(negedge clk);
    main_tick = 1'b0; sub_tick = 1'b0;
    c = cyc_en; p = psc_tap; w = watch_tap;
  endtask

  task automatic run(input bit is_sub, input int n, output int np, output int first, output int last);
    logic c; logic [PSC_BITS-1:0] p; logic [WP_BITS-1:0] w;
    np = 0; first = 0; last = 0;
    for (int k = 1; k <= n; k++) begin
      tick(is_sub, c, p, w);
      if (c) begin
        np++; last = k;
        if (first == 0) first = k;
      end
    end
  endtask

  task automatic flush_main();
    logic c; logic [PSC_BITS-1:0] p; logic [WP_BITS-1:0] w;
    c = 1'b0;
    for (int k = 0; k < 40 && !c; k++) tick(1'b0, c, p, w);
  endtask

  task automatic t_reset_r1();
    int np, f, l;
    do_reset();
    check("R1 cyc_en after reset", int'(cyc_en), 0);
    check("R1 psc_tap after reset", int'(psc_tap), 0);
    check("R1 watch_tap after reset", int'(watch_tap), 0);
    run(1'b0, 31, np, f, l);
    check("R1 no pulse before 32 ticks", np, 0);
    run(1'b0, 1, np, f, l);
    check("R1 pulse at tick 32", np, 1);
    @(negedge clk);
    check("R8 cyc_en one cycle long", int'(cyc_en), 0);
  endtask

  task automatic t_divisors_r2();
    int np, f, l, len;
    for (int s = 0; s < 4; s++) begin
      div_sel = 2'(s);
      flush_main();
      len = 4 << s;
      run(1'b0, 3 * len, np, f, l);
      check($sformatf("R2 sel %0d pulse count", s), np, 3);
      check($sformatf("R2 sel %0d first pulse", s), f, len);
      check($sformatf("R2 sel %0d last pulse", s), l, 3 * len);
    end
  endtask

  task automatic t_change_r3();
    int np, f, l;
    do_reset();
    run(1'b0, 20, np, f, l);
    div_sel = 2'b00;
    run(1'b0, 12, np, f, l);
    check("R3 /32 cycle finishes after down change", f, 12);
    check("R3 one pulse in old cycle", np, 1);
    run(1'b0, 8, np, f, l);
    check("R3 /4 in effect after boundary", l, 8);
    run(1'b0, 2, np, f, l);
    div_sel = 2'b11;
    run(1'b0, 2, np, f, l);
    check("R3 /4 cycle finishes after up change", f, 2);
    run(1'b0, 32, np, f, l);
    check("R3 /32 in effect after boundary", f, 32);
    div_sel = 2'b00;
    flush_main();
  endtask

  task automatic t_sub_r4();
    int np, f, l;
    sub_mode = 1'b1; sub_div_sel = 1'b0;
    flush_main();
    run(1'b0, 64, np, f, l);
    check("R4 main ticks ignored in sub mode", np, 0);
    run(1'b1, 8, np, f, l);
    check("R4 sub /4 count", np, 2);
    check("R4 sub /4 last", l, 8);
    sub_div_sel = 1'b1;
    run(1'b1, 12, np, f, l);
    check("R4 sub select at boundary first", f, 4);
    check("R4 sub /8 last", l, 12);
  endtask

  task automatic t_return_r5();
    int np, f, l;
    run(1'b0, 3, np, f, l);
    check("R5 main ticks in sub mode", np, 0);
    sub_mode = 1'b0;
    run(1'b1, 8, np, f, l);
    check("R5 switch at sub boundary", f, 8);
    run(1'b1, 16, np, f, l);
    check("R5 sub ticks ignored in active", np, 0);
    run(1'b0, 4, np, f, l);
    check("R5 full /4 cycle after return", f, 4);
    check("R5 single pulse after return", np, 1);
  endtask

  task automatic t_prescaler_r6();
    logic c; logic [PSC_BITS-1:0] p; logic [WP_BITS-1:0] w;
    int cyc_n, bad;
    int cnt [PSC_BITS];
    int first [PSC_BITS];
    do_reset();
    div_sel = 2'b00;
    cyc_n = 0; bad = 0;
    for (int i = 0; i < PSC_BITS; i++) begin cnt[i] = 0; first[i] = 0; end
    while (cyc_n < 2048) begin
      tick(1'b0, c, p, w);
      if (c) cyc_n++;
      for (int i = 0; i < PSC_BITS; i++) begin
        if (p[i]) begin
          cnt[i]++;
          if (first[i] == 0) first[i] = cyc_n;
          if (!c || (cyc_n % (2 << i)) != 0) bad++;
        end
      end
    end
    for (int i = 0; i < PSC_BITS; i++) begin
      check($sformatf("R6 tap %0d count", i), cnt[i], 2048 >> (i + 1));
      check($sformatf("R6 tap %0d first", i), first[i], 2 << i);
    end
    check("R6 taps aligned with cyc_en", bad, 0);
  endtask

  task automatic t_watch_r7();
    logic c; logic [PSC_BITS-1:0] p; logic [WP_BITS-1:0] w;
    int sub_n;
    int cnt [WP_BITS];
    int first [WP_BITS];
    do_reset();
    sub_n = 0;
    for (int j = 0; j < WP_BITS; j++) begin cnt[j] = 0; first[j] = 0; end
    for (int k = 0; k < 2048; k++) begin
      if (k == 1000) begin
        sub_mode = 1'b1;
        for (int m = 0; m < 32; m++) begin
          tick(1'b0, c, p, w);
          for (int j = 0; j < WP_BITS; j++) if (w[j]) cnt[j] += 100;
        end
      end
      tick(1'b1, c, p, w);
      sub_n++;
      for (int j = 0; j < WP_BITS; j++) begin
        if (w[j]) begin
          cnt[j]++;
          if (first[j] == 0) first[j] = sub_n;
        end
      end
    end
    for (int j = 0; j < WP_BITS; j++) begin
      check($sformatf("R7 watch tap %0d count", j), cnt[j], 128 >> j);
      check($sformatf("R7 watch tap %0d first", j), first[j], 16 << j);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    t_reset_r1();
    t_divisors_r2();
    t_change_r3();
    t_sub_r4();
    t_return_r5();
    t_prescaler_r6();
    t_watch_r7();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    finish_run();
  end

endmodule